// File: doc/BRIEF.md
# Strobe/Acknowledge Register Slice

This block sits between two links that use the same valid-and-ready style handshake. On each link the sender raises a strobe with a word of data and the receiver raises an acknowledge. A word moves on every rising clock edge where both are high. The slice receives words from the upstream link and sends them, in arrival order, on the downstream link.

Every output of the slice comes straight from a flop. No combinational path runs from one link to the other, so timing closes on each side on its own. Storage is one main slot and one overflow slot. The upstream acknowledge is a registered signal. When a word arrives in the same cycle that the downstream receiver stalls, the overflow slot holds it. The slice therefore accepts one word per cycle under continuous flow and still keeps its acknowledge steady.

A single clock serves both links. Reset is synchronous and active low. The payload width is a parameter.

Top module: `sa_pipe_stage`

## Requirements
- R1: At a rising edge where `rst_n` is 0, the slice drops every word it holds and sets `dn_stb` and `up_ack` to 0. They stay at 0 for as long as `rst_n` stays low, and no word offered upstream during reset ever appears downstream.
- R2: On the first rising edge with `rst_n` at 1 after a reset, with the slice empty, `up_ack` goes to 1.
- R3: When a word is accepted into an empty slice, `dn_stb` is 1 and `dn_data` shows that word after that same edge. This holds whatever the value of `dn_ack`. When the slice holds nothing, `dn_stb` is 0.
- R4: While `dn_stb` is 1 and `dn_ack` is 0 at an edge, `dn_stb` stays 1 and `dn_data` stays unchanged after that edge.
- R5: While `up_ack` is 1 and `up_stb` is 0 at an edge, `up_ack` stays 1 after that edge.
- R6: A word moves on every edge where the strobe and acknowledge of a link are both 1. With `up_stb` and `dn_ack` both held at 1, the slice takes in and sends out one word per cycle, with no idle cycle between words.
- R7: The slice holds at most two words. With `dn_ack` held at 0, it accepts exactly two words and then holds `up_ack` at 0.
- R8: Words leave in the order they entered. No word is duplicated or lost under any pattern of wait states on either link.
- R9: Whenever the slice holds fewer than two words (except on the first cycle out of reset), `up_ack` is 1. In particular, `up_ack` returns to 1 on the edge after a downstream transfer frees a full slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| up_data | input | WIDTH | Payload offered by the upstream sender |
| up_stb | input | 1 | Upstream sender has a valid word |
| up_ack | output | 1 | Slice is ready to take an upstream word |
| dn_data | output | WIDTH | Payload offered to the downstream receiver |
| dn_stb | output | 1 | Slice has a valid word for downstream |
| dn_ack | input | 1 | Downstream receiver is ready |

## Verification
The hardest state to reach is the one where a word arrives in the same cycle the downstream receiver stalls. That word must go into the overflow slot, and on a later edge it must move forward into the main slot as the older word leaves. A directed scenario sets this up on purpose. It holds `dn_ack` low while feeding three words, then releases the receiver for one edge, stalls it again, and checks the order the words come out and when `up_ack` returns. A long run with independent random wait states on both links then reaches all the other mixes of fill, drain and simultaneous transfer. It compares every word leaving downstream with a queue of the words accepted upstream.

// File: rtl/sa_pipe_pkg.sv
// Package: shared types for the strobe/acknowledge register slice.
// Assumes: nothing beyond standard SystemVerilog.
package sa_pipe_pkg;

    // How many words the slice currently holds.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2
    } occ_e;

endpackage

// File: rtl/sa_pipe_slot.sv
// Module: sa_pipe_slot
// One payload register with a load enable. It holds its value whenever
// load is low.
// Assumes: the controller decides when the contents are valid; the data
// itself needs no reset.
module sa_pipe_slot #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture new payload only when told to.
    always_ff @(posedge clk) begin
        if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sa_pipe_ctrl.sv
// Module: sa_pipe_ctrl
// Occupancy controller of the register slice. It tracks how many words are
// held (0, 1 or 2), produces both registered handshake outputs, and steers
// loads into the main and overflow slots.
// Assumes: synchronous active-low reset; the upstream sender keeps up_stb
// asserted until a transfer (the slice does not rely on it for correctness).
module sa_pipe_ctrl
    import sa_pipe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_stb,
    input  logic dn_ack,
    output logic up_ack,
    output logic dn_stb,
    output logic main_load,
    output logic main_from_up,
    output logic skid_load
);

    occ_e occ_q;
    occ_e occ_d;
    logic ack_q;
    logic up_fire;
    logic dn_fire;

    assign up_fire = up_stb && ack_q;
    assign dn_fire = (occ_q != OCC_EMPTY) && dn_ack;

    // Next occupancy and slot steering from the two transfer events.
    always_comb begin
        occ_d        = occ_q;
        main_load    = 1'b0;
        main_from_up = 1'b1;
        skid_load    = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (up_fire) begin
                    main_load = 1'b1;
                    occ_d     = OCC_ONE;
                end
            end
            OCC_ONE: begin
                if (up_fire && dn_fire) begin
                    main_load = 1'b1;
                end else if (up_fire) begin
                    skid_load = 1'b1;
                    occ_d     = OCC_TWO;
                end else if (dn_fire) begin
                    occ_d     = OCC_EMPTY;
                end
            end
            OCC_TWO: begin
                if (dn_fire) begin
                    main_load    = 1'b1;
                    main_from_up = 1'b0;
                    occ_d        = OCC_ONE;
                end
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // Occupancy and acknowledge registers; ack drops only when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            ack_q <= 1'b0;
        end else begin
            occ_q <= occ_d;
            ack_q <= (occ_d != OCC_TWO);
        end
    end

    assign up_ack = ack_q;
    assign dn_stb = (occ_q != OCC_EMPTY);

endmodule

// File: rtl/sa_pipe_stage.sv
// Module: sa_pipe_stage (top)
// Register slice between two strobe/acknowledge links. It has a main slot
// and an overflow slot. Every output is driven from a flop, so no
// combinational path runs from one link to the other.
// Assumes: one clock for both links; synchronous active-low reset.
module sa_pipe_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] up_data,
    input  logic             up_stb,
    output logic             up_ack,
    output logic [WIDTH-1:0] dn_data,
    output logic             dn_stb,
    input  logic             dn_ack
);

    logic             main_load;
    logic             main_from_up;
    logic             skid_load;
    logic [WIDTH-1:0] skid_q;
    logic [WIDTH-1:0] main_d;

    sa_pipe_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .up_stb       (up_stb),
        .dn_ack       (dn_ack),
        .up_ack       (up_ack),
        .dn_stb       (dn_stb),
        .main_load    (main_load),
        .main_from_up (main_from_up),
        .skid_load    (skid_load)
    );

    // Main slot takes new data directly, or the parked word when draining.
    assign main_d = main_from_up ? up_data : skid_q;

    sa_pipe_slot #(.WIDTH(WIDTH)) u_main (
        .clk  (clk),
        .load (main_load),
        .d    (main_d),
        .q    (dn_data)
    );

    sa_pipe_slot #(.WIDTH(WIDTH)) u_skid (
        .clk  (clk),
        .load (skid_load),
        .d    (up_data),
        .q    (skid_q)
    );

endmodule

// File: rtl/sa_pipe_stage_chk.sv
// Module: sa_pipe_stage_chk
// Protocol and capacity checker, bound to sa_pipe_stage. It keeps its own
// word count from the transfers seen at the ports.
// Assumes: bound with the same WIDTH as the stage.
module sa_pipe_stage_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] up_data,
    input logic             up_stb,
    input logic             up_ack,
    input logic [WIDTH-1:0] dn_data,
    input logic             dn_stb,
    input logic             dn_ack
);

    logic       seen = 1'b0;
    logic [2:0] held;

    // Marks that at least one edge has passed.
    always_ff @(posedge clk) begin
        seen <= 1'b1;
    end

    // Words in flight, counted from port transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 3'd0;
        end else begin
            held <= held + {2'b00, (up_stb && up_ack)} - {2'b00, (dn_stb && dn_ack)};
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        seen && !$past(rst_n) |-> !dn_stb && !up_ack);

    assert_strobe_when_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dn_stb == (held != 3'd0)));

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stb && !dn_ack |=> dn_stb && $stable(dn_data));

    assert_ack_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack && !up_stb |=> up_ack);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held <= 3'd2) && ((held == 3'd2) -> !up_ack));

    assert_ready_when_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (held < 3'd2) |-> up_ack);

endmodule

bind sa_pipe_stage sa_pipe_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_data (up_data),
    .up_stb  (up_stb),
    .up_ack  (up_ack),
    .dn_data (dn_data),
    .dn_stb  (dn_stb),
    .dn_ack  (dn_ack)
);

// File: tb/sim_sa_pipe_stage.sv
`timescale 1ns/1ps
// Bench for sa_pipe_stage: directed scenarios plus a random wait-state run.
// A background monitor keeps a scoreboard of accepted words and checks the
// sticky handshake rules.
module sim_sa_pipe_stage;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] up_data = '0;
    logic         up_stb = 1'b0;
    logic         up_ack;
    logic [W-1:0] dn_data;
    logic         dn_stb;
    logic         dn_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int rx_count = 0;
    bit mon_up_fire = 1'b0;
    bit mon_dn_fire = 1'b0;
    logic [W-1:0] exp_q[$];

    sa_pipe_stage #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_stb(up_stb),
        .up_ack(up_ack), .dn_data(dn_data), .dn_stb(dn_stb), .dn_ack(dn_ack)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: samples late in each cycle, away from the rising edge.
    logic         p_rst = 1'b0, p_dstb = 1'b0, p_dack = 1'b0, p_uack = 1'b0, p_ustb = 1'b0;
    logic [W-1:0] p_ddata = '0;
    always begin
        @(negedge clk); #3;
        mon_up_fire = 1'b0;
        mon_dn_fire = 1'b0;
        if (!rst_n) begin
            exp_q.delete();
        end else begin
            if (up_stb && up_ack) begin
                exp_q.push_back(up_data);
                mon_up_fire = 1'b1;
            end
            if (dn_stb && dn_ack) begin
                mon_dn_fire = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 spurious word", 32'(dn_data), 32'hffff_ffff);
                end else begin
                    logic [W-1:0] w;
                    w = exp_q.pop_front();
                    chk(dn_data == w, "R8 order", 32'(dn_data), 32'(w));
                    rx_count++;
                end
            end
            if (p_rst && p_dstb && !p_dack)
                chk(dn_stb && dn_data == p_ddata, "R4 hold", {15'd0, dn_stb, dn_data},
                    {15'd0, 1'b1, p_ddata});
            if (p_rst && p_uack && !p_ustb)
                chk(up_ack, "R5 ack sticky", 32'(up_ack), 32'd1);
        end
        p_rst = rst_n; p_dstb = dn_stb; p_dack = dn_ack; p_ddata = dn_data;
        p_uack = up_ack; p_ustb = up_stb;
    end

    // Reset state, words offered in reset ignored, ready after release.
    task automatic t_reset();
        rst_n = 1'b0; up_stb = 1'b1; up_data = 16'hdead; dn_ack = 1'b1;
        repeat (3) begin
            @(negedge clk); #3;
            chk(!dn_stb && !up_ack, "R1 reset outputs", {dn_stb, up_ack}, 0);
        end
        @(negedge clk); rst_n = 1'b1; up_stb = 1'b0; dn_ack = 1'b0;
        #3 chk(!up_ack, "R1 ack low before first edge", 32'(up_ack), 0);
        @(negedge clk); #3;
        chk(up_ack == 1'b1, "R2 ready after reset", 32'(up_ack), 1);
        chk(!dn_stb, "R1 no word kept from reset", 32'(dn_stb), 0);
    endtask

    // One word into an empty slice while the receiver stalls.
    task automatic t_single();
        @(negedge clk); up_stb = 1'b1; up_data = 16'h1234; dn_ack = 1'b0;
        @(negedge clk); up_stb = 1'b0; up_data = 16'hxxxx;
        #3 chk(dn_stb && dn_data == 16'h1234, "R3 strobe after one edge",
               {15'd0, dn_stb, dn_data}, {15'd0, 1'b1, 16'h1234});
        repeat (3) begin
            @(negedge clk); #3;
            chk(dn_stb && dn_data == 16'h1234, "R4 held while stalled",
                {15'd0, dn_stb, dn_data}, {15'd0, 1'b1, 16'h1234});
        end
        @(negedge clk); dn_ack = 1'b1;
        @(negedge clk); dn_ack = 1'b0;
        #3 chk(!dn_stb, "R3 strobe low when empty", 32'(dn_stb), 0);
    endtask

    // Fill both slots, check capacity, then release one word at a time.
    task automatic t_fill();
        @(negedge clk); up_stb = 1'b1; up_data = 16'h00a1; dn_ack = 1'b0;
        #3 chk(up_ack, "R7 ready when empty", 32'(up_ack), 1);
        @(negedge clk); up_data = 16'h00b2;
        #3 chk(up_ack, "R7 ready with one held", 32'(up_ack), 1);
        @(negedge clk); up_data = 16'h00c3;
        #3 chk(!up_ack, "R7 full after two", 32'(up_ack), 0);
        repeat (3) begin
            @(negedge clk); #3;
            chk(!up_ack && dn_data == 16'h00a1, "R7 stays full",
                {up_ack, 15'd0, dn_data}, {16'd0, 16'h00a1});
        end
        @(negedge clk); dn_ack = 1'b1;
        @(negedge clk); dn_ack = 1'b0;
        #3 chk(up_ack, "R9 ack back after drain", 32'(up_ack), 1);
        chk(dn_data == 16'h00b2, "R8 parked word moves up", 32'(dn_data), 32'h00b2);
        @(negedge clk); up_stb = 1'b0;
        #3 chk(!up_ack, "R7 full again", 32'(up_ack), 0);
        @(negedge clk); dn_ack = 1'b1;
        @(negedge clk);
        @(negedge clk); dn_ack = 1'b0;
        #3 chk(!dn_stb && up_ack, "R9 empty and ready", {dn_stb, up_ack}, 32'b01);
    endtask

    // Continuous flow: one word per cycle in and out.
    task automatic t_stream();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); up_stb = 1'b1; up_data = 16'h5000 + 16'(i); dn_ack = 1'b1;
            #3 chk(up_ack, "R6 ack every cycle", 32'(up_ack), 1);
            if (i > 0)
                chk(dn_stb && dn_data == 16'h5000 + 16'(i - 1), "R6 out every cycle",
                    {15'd0, dn_stb, dn_data}, {15'd0, 1'b1, 16'h5000 + 16'(i - 1)});
        end
        @(negedge clk); up_stb = 1'b0;
        #3 chk(dn_stb && dn_data == 16'h500f, "R6 last word", 32'(dn_data), 32'h500f);
        @(negedge clk); dn_ack = 1'b0;
        #3 chk(!dn_stb, "R6 drained", 32'(dn_stb), 0);
    endtask

    // Reset while full: contents discarded.
    task automatic t_mid_reset();
        @(negedge clk); up_stb = 1'b1; up_data = 16'h0771; dn_ack = 1'b0;
        @(negedge clk); up_data = 16'h0772;
        @(negedge clk); up_stb = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        #3 chk(!dn_stb && !up_ack, "R1 reset while full", {dn_stb, up_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk); dn_ack = 1'b1;
        #3 chk(up_ack && !dn_stb, "R1 contents dropped", {dn_stb, up_ack}, 32'b01);
        @(negedge clk); dn_ack = 1'b0;
        #3 chk(!dn_stb, "R1 nothing leaves", 32'(dn_stb), 0);
    endtask

    // Random wait states on both links, scoreboarded by the monitor.
    task automatic t_random(input int n);
        int sent = 0;
        int start = rx_count;
        int guard = 0;
        while ((rx_count - start) < n && guard < 40000) begin
            @(negedge clk);
            guard++;
            if (!up_stb || mon_up_fire) begin
                if (sent < n && ($urandom % 3) != 0) begin
                    up_stb = 1'b1; up_data = W'($urandom); sent++;
                end else begin
                    up_stb = 1'b0;
                end
            end
            if (!dn_ack || mon_dn_fire) dn_ack = (($urandom % 2) == 1);
        end
        @(negedge clk); up_stb = 1'b0; dn_ack = 1'b0;
        chk(rx_count - start == n, "R8 all words delivered", 32'(rx_count - start), 32'(n));
        chk(exp_q.size() == 0, "R8 nothing left over", 32'(exp_q.size()), 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(17));
        t_reset();
        t_single();
        t_fill();
        t_stream();
        t_mid_reset();
        t_random(600);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule